// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned operands over many clock cycles and returns a product twice their width. With the default width of 32 bits it retires one multiplier bit per clock, so a result is ready 32 cycles after the request. The hardware is kept small: one double-width accumulator register, one register for the multiplicand, one single-width adder and an iteration counter.

At launch, the lower half of the accumulator is loaded with the multiplier and the upper half is cleared. In each cycle the block looks at accumulator bit 0. When that bit is set, the multiplicand is added into the upper half. The adder's carry is kept, and the whole accumulator, with the carry on top, then moves one place to the right. As the multiplier bits are used up they are shifted out, and product bits take their place from the top.

A client pulses `start_i` while the block is idle. It then waits for the one-cycle `done_o` pulse and reads `product_o`. That output holds its value until the next accepted start.

Top module: `shift_add_mul`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, busy_o is 0, done_o is 0 and product_o is 0.
- R2: When start_i is 1 at a rising edge while busy_o is 0, the operands are captured and busy_o is 1 after that edge.
- R3: done_o rises exactly 32 rising edges after the edge that accepted the start, and busy_o falls at that same edge.
- R4: When done_o is 1, product_o equals the unsigned 64-bit product of the captured multiplicand and multiplier, for any operand values including zero and one.
- R5: The carry out of each addition is kept, so all-ones times all-ones gives 0xFFFFFFFE00000001 with no high bits lost.
- R6: A start_i pulse while busy_o is 1 is ignored: the running operation keeps its operands and its done timing.
- R7: done_o is high for exactly one cycle per operation.
- R8: While the block is idle and start_i is 0, product_o does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a multiply; accepted only when idle |
| mcand_i | input | 32 | Unsigned multiplicand, sampled on an accepted start |
| mplier_i | input | 32 | Unsigned multiplier, sampled on an accepted start |
| busy_o | output | 1 | High while an operation is in progress |
| done_o | output | 1 | One-cycle pulse when the product is ready |
| product_o | output | 64 | Unsigned 64-bit product, held until the next accepted start |

## Verification
The product is checked for several kinds of operands, and each kind exposes a different fault:
- Zero operands show whether the upper half is actually cleared at launch.
- Multiplying by one shows whether the shift count is right and the result is aligned.
- Alternating bit patterns exercise both the add path and the skip path, so they catch a wrong test of bit 0.
- All-ones operands are the only case that needs the carry, so they reveal a dropped carry bit.

A second start issued halfway through an operation, with different operands, shows whether the block restarts or corrupts its result. Idle periods of several cycles show whether product_o stays stable while nothing is running.

// File: rtl/mul_pkg.sv
package mul_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;
endpackage

// File: rtl/mul_step_adder.sv
module mul_step_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] hi_i,
    input  logic [W-1:0] mcand_i,
    input  logic         add_en_i,
    output logic [W:0]   sum_o
);
    always_comb begin
        if (add_en_i) begin
            sum_o = {1'b0, hi_i} + {1'b0, mcand_i};
        end else begin
            sum_o = {1'b0, hi_i};
        end
    end
endmodule

// File: rtl/mul_iter_count.sv
module mul_iter_count #(
    parameter int ITER = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic step_i,
    output logic last_o
);
    localparam int CW = (ITER > 1) ? $clog2(ITER) : 1;
    localparam logic [CW-1:0] LAST = CW'(ITER - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (step_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last_o = (cnt_q == LAST);
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [W-1:0]   mcand_i,
    input  logic [W-1:0]   mplier_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [2*W-1:0] product_o
);
    import mul_pkg::*;

    localparam int PW = 2 * W;

    typedef struct packed {
        phase_e          phase;
        logic            done;
        logic [W-1:0]    mcand;
        logic [PW-1:0]   acc;
    } state_t;

    state_t st_d, st_q;

    logic          accept;
    logic          running;
    logic          last_iter;
    logic [W:0]    sum;

    assign running = (st_q.phase == PH_RUN);
    assign accept  = start_i && !running;

    mul_step_adder #(.W(W)) u_adder (
        .hi_i     (st_q.acc[PW-1:W]),
        .mcand_i  (st_q.mcand),
        .add_en_i (st_q.acc[0]),
        .sum_o    (sum)
    );

    mul_iter_count #(.ITER(W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .step_i  (running),
        .last_o  (last_iter)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (accept) begin
            st_d.phase = PH_RUN;
            st_d.mcand = mcand_i;
            st_d.acc   = {{W{1'b0}}, mplier_i};
        end else if (running) begin
            st_d.acc = {sum, st_q.acc[W-1:1]};
            if (last_iter) begin
                st_d.phase = PH_IDLE;
                st_d.done  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, done: 1'b0, mcand: '0, acc: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o    = running;
    assign done_o    = st_q.done;
    assign product_o = st_q.acc;
endmodule

// File: rtl/shift_add_mul_chk.sv
module shift_add_mul_chk #(
    parameter int W = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start_i,
    input logic [W-1:0]   mcand_i,
    input logic [W-1:0]   mplier_i,
    input logic           busy_o,
    input logic           done_o,
    input logic [2*W-1:0] product_o
);
    localparam int CW = $clog2(W + 2);

    logic [CW-1:0]  len_q;
    logic [W-1:0]   cap_a_q, cap_b_q;
    logic [2*W-1:0] want;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q   <= '0;
            cap_a_q <= '0;
            cap_b_q <= '0;
        end else if (start_i && !busy_o) begin
            len_q   <= '0;
            cap_a_q <= mcand_i;
            cap_b_q <= mplier_i;
        end else if (busy_o) begin
            len_q <= len_q + 1'b1;
        end
    end

    assign want = {{W{1'b0}}, cap_a_q} * {{W{1'b0}}, cap_b_q};

    p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    p_done_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (len_q == CW'(W)) && !busy_o && $past(busy_o));

    p_product_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (product_o == want));

    p_busy_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (busy_o || done_o));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_idle_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(product_o));
endmodule

bind shift_add_mul shift_add_mul_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .product_o (product_o)
);

// File: tb/tb_shift_add_mul.sv
module tb_shift_add_mul;
    localparam int W = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic [W-1:0]   mcand_i = '0;
    logic [W-1:0]   mplier_i = '0;
    logic           busy_o;
    logic           done_o;
    logic [2*W-1:0] product_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    shift_add_mul #(.W(W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .mcand_i   (mcand_i),
        .mplier_i  (mplier_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .product_o (product_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Launch at a negedge; returns edges from accepting edge to done.
    task automatic run_mul(input logic [31:0] a, input logic [31:0] b,
                           input bit mid_start, output int edges);
        edges = 0;
        mcand_i  = a;
        mplier_i = b;
        start_i  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        check("R2 busy after start", 64'(busy_o), 64'd1);
        while (!done_o && edges < 100) begin
            if (mid_start && edges == 10) begin
                mcand_i  = 32'h1234_5678;
                mplier_i = 32'h0000_0003;
                start_i  = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            @(posedge clk);
            edges++;
            @(negedge clk);
        end
        start_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 busy at reset", 64'(busy_o), 64'd0);
        check("R1 done at reset", 64'(done_o), 64'd0);
        check("R1 product at reset", product_o, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after release", 64'(busy_o), 64'd0);
        check("R1 product after release", product_o, 64'd0);
    endtask

    task automatic t_mul(input string tag, input logic [31:0] a, input logic [31:0] b);
        int e;
        run_mul(a, b, 1'b0, e);
        check({tag, " R3 latency"}, 64'(e), 64'd32);
        check({tag, " R3 busy low at done"}, 64'(busy_o), 64'd0);
        check({tag, " R4 product"}, product_o, {32'd0, a} * {32'd0, b});
        @(negedge clk);
        check({tag, " R7 done one cycle"}, 64'(done_o), 64'd0);
    endtask

    task automatic t_carry_r5();
        int e;
        run_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, e);
        check("R5 all ones product", product_o, 64'hFFFF_FFFE_0000_0001);
    endtask

    task automatic t_ignore_r6();
        int e;
        run_mul(32'h0001_0001, 32'h8000_0001, 1'b1, e);
        check("R6 latency unchanged", 64'(e), 64'd32);
        check("R6 first operands kept", product_o,
              {32'd0, 32'h0001_0001} * {32'd0, 32'h8000_0001});
    endtask

    task automatic t_idle_r8();
        logic [63:0] held;
        held = product_o;
        mcand_i  = 32'hDEAD_BEEF;
        mplier_i = 32'hCAFE_F00D;
        repeat (6) @(negedge clk);
        check("R8 product held while idle", product_o, held);
        check("R8 still idle", 64'(busy_o), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_mul("small", 32'd6, 32'd7);
        t_mul("zero mcand", 32'd0, 32'hFFFF_FFFF);
        t_mul("zero mplier", 32'h89AB_CDEF, 32'd0);
        t_mul("by one", 32'h1357_9BDF, 32'd1);
        t_mul("alt bits", 32'hAAAA_AAAA, 32'h5555_5555);
        t_mul("msb only", 32'h8000_0000, 32'h8000_0000);
        t_carry_r5();
        t_ignore_r6();
        t_idle_r8();
        t_mul("after idle", 32'h0000_FFFF, 32'hFFFF_0000);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule